// File: doc/BRIEF.md
# Reuse-Count Global Victim Selector

This block chooses which entry of a decoupled data array gets evicted next. Replacement is global, not per set. Every data entry keeps a valid bit, a small saturating reuse counter and the index of the tag entry that owns it. A hit to an entry raises its counter. A single search pointer is shared by the whole array. When a victim is requested, the pointer sweeps forward one entry per clock. Each entry it passes loses one count. The sweep stops at the first entry that is empty or has no reuse left.

The surrounding cache controller asks for a victim while `req_ready` is high. It waits for the one-cycle `victim_valid` pulse, which carries the chosen index, the stored tag back-pointer and whether the entry held a block. It then installs the incoming block at that index through the fill port. The fill marks the entry valid, records its owner and clears its counter. Hits can be reported in any cycle, including cycles in which a sweep is running.

Top module: `reuse_victim_sel`

## Requirements
- R1: After reset every entry is empty, `victim_valid` is low, `req_ready` is high, and the first search examines index 0 first.
- R2: A fill at an index makes that entry valid, sets its counter to zero and stores `fill_tptr`. A later victim report for that entry returns this value on `victim_tptr`.
- R3: A hit raises the entry's counter by one. The counter is `CNT_W` bits wide (2 by default) and holds at its maximum value of 3.
- R4: Each entry the sweep examines and does not choose loses one count.
- R5: A search starts at the index after the search pointer, wraps from the last index to 0, and chooses the first valid entry whose count is zero.
- R6: An empty entry met during the sweep is chosen at once. `victim_occupied` is 0 for it and 1 for a chosen entry that holds a block.
- R7: The sweep examines one entry per clock. After the edge that accepts a request, the victim is reported after exactly as many edges as entries were examined. `victim_valid` is high for one cycle only.
- R8: After a choice, the search pointer rests on the chosen index, so the next search begins just after it.
- R9: A hit and a sweep decrement to the same entry in the same cycle leave its counter unchanged.
- R10: A fill to an entry wins over a hit or a decrement to that entry in the same cycle.
- R11: `req_ready` is high exactly when no search is running. A request is taken only while it is high and is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | 1 | Hit report strobe |
| hit_idx | input | IDX_W | Entry that was hit |
| fill_vld | input | 1 | Fill strobe |
| fill_idx | input | IDX_W | Entry being filled |
| fill_tptr | input | TPTR_W | Owning tag index stored with the fill |
| victim_req | input | 1 | Request for a victim search |
| req_ready | output | 1 | High while idle; a request is accepted then |
| victim_valid | output | 1 | One-cycle pulse with the chosen victim |
| victim_idx | output | IDX_W | Chosen entry index |
| victim_tptr | output | TPTR_W | Stored tag back-pointer of the chosen entry |
| victim_occupied | output | 1 | Chosen entry held a valid block |

## Verification
A hit and a sweep decrement can land on the same entry in the same clock. A fill can also coincide with a hit or a decrement to that entry. The directed part of the bench times a hit to arrive on the edge where the sweep examines that entry. It raises the other counts so that the sweep laps the array three times. As a result, a lost hit or a double decrement shows up as a different victim index and latency. A second directed case pairs a fill with a hit on the same entry. A long pseudo-random phase then mixes hits, fills and requests every cycle. It compares every cycle against a bench model built from the requirements.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
   typedef enum logic {
      RVS_IDLE = 1'b0,
      RVS_SCAN = 1'b1
   } rvs_state_e;

   function automatic int unsigned rvs_idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rvs_entry.sv
module rvs_entry #(
   parameter int unsigned CNT_W  = 2,
   parameter int unsigned TPTR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [TPTR_W-1:0] fill_tptr,
   input  logic              hit_en,
   input  logic              dec_en,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              valid_o,
   output logic [TPTR_W-1:0] tptr_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_o;
      if (fill_en) begin
         cnt_d = '0;
      end else if (hit_en && !dec_en) begin
         if (cnt_o != CNT_MAX) cnt_d = cnt_o + CNT_ONE;
      end else if (dec_en && !hit_en) begin
         if (cnt_o != '0) cnt_d = cnt_o - CNT_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o   <= '0;
         valid_o <= 1'b0;
         tptr_o  <= '0;
      end else begin
         cnt_o <= cnt_d;
         if (fill_en) begin
            valid_o <= 1'b1;
            tptr_o  <= fill_tptr;
         end
      end
   end

   AST_FILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (valid_o && cnt_o == '0)); // R2
   AST_HIT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_en && !dec_en && !fill_en && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX); // R3
   AST_HIT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_en && !dec_en && !fill_en) |=> cnt_o != '0); // R3
   AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && !hit_en && !fill_en && cnt_o == '0) |=> cnt_o == '0); // R4
   AST_HIT_DEC_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_en && dec_en && !fill_en) |=> $stable(cnt_o)); // R9
endmodule

// File: rtl/rvs_sweep.sv
module rvs_sweep
   import rvs_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 8,
   parameter int unsigned TPTR_W    = 6,
   localparam int unsigned IDX_W    = rvs_idx_w(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              cur_valid,
   input  logic              cur_zero,
   input  logic [TPTR_W-1:0] cur_tptr,
   output logic              req_ready,
   output logic              scanning,
   output logic              pick,
   output logic [IDX_W-1:0]  cur_idx,
   output logic              victim_valid,
   output logic [IDX_W-1:0]  victim_idx,
   output logic [TPTR_W-1:0] victim_tptr,
   output logic              victim_occupied
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);
   localparam logic [IDX_W-1:0] STEP = {{(IDX_W-1){1'b0}}, 1'b1};

   rvs_state_e      state_q;
   logic [IDX_W-1:0] ptr_q;

   function automatic logic [IDX_W-1:0] wrap_next(input logic [IDX_W-1:0] i);
      return (i == LAST) ? '0 : i + STEP;
   endfunction

   assign scanning  = (state_q == RVS_SCAN);
   assign req_ready = (state_q == RVS_IDLE);
   assign pick      = scanning && (!cur_valid || cur_zero);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q         <= RVS_IDLE;
         ptr_q           <= LAST;
         cur_idx         <= '0;
         victim_valid    <= 1'b0;
         victim_idx      <= '0;
         victim_tptr     <= '0;
         victim_occupied <= 1'b0;
      end else begin
         victim_valid <= 1'b0;
         if (state_q == RVS_IDLE) begin
            if (req) begin
               state_q <= RVS_SCAN;
               cur_idx <= wrap_next(ptr_q);
            end
         end else if (pick) begin
            state_q         <= RVS_IDLE;
            ptr_q           <= cur_idx;
            victim_valid    <= 1'b1;
            victim_idx      <= cur_idx;
            victim_tptr     <= cur_tptr;
            victim_occupied <= cur_valid;
         end else begin
            cur_idx <= wrap_next(cur_idx);
         end
      end
   end

   AST_VICTIM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |=> !victim_valid); // R7
   AST_SCAN_STARTS_AFTER_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scanning) |-> cur_idx == wrap_next(ptr_q)); // R5
   AST_SCAN_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (scanning && !pick) |=> cur_idx == wrap_next($past(cur_idx))); // R7
   AST_BUSY_NO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> !victim_valid); // R11
endmodule

// File: rtl/reuse_victim_sel.sv
module reuse_victim_sel
   import rvs_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 8,
   parameter int unsigned CNT_W     = 2,
   parameter int unsigned TPTR_W    = 6,
   localparam int unsigned IDX_W    = rvs_idx_w(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_vld,
   input  logic [IDX_W-1:0]  hit_idx,
   input  logic              fill_vld,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [TPTR_W-1:0] fill_tptr,
   input  logic              victim_req,
   output logic              req_ready,
   output logic              victim_valid,
   output logic [IDX_W-1:0]  victim_idx,
   output logic [TPTR_W-1:0] victim_tptr,
   output logic              victim_occupied
);
   if (N_ENTRIES < 2) begin : g_bad_depth
      $error("reuse_victim_sel: N_ENTRIES must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("reuse_victim_sel: CNT_W must be at least 1");
   end
   if (TPTR_W < 1) begin : g_bad_tptr
      $error("reuse_victim_sel: TPTR_W must be at least 1");
   end

   logic [CNT_W-1:0]  cnt_a   [N_ENTRIES];
   logic              valid_a [N_ENTRIES];
   logic [TPTR_W-1:0] tptr_a  [N_ENTRIES];

   logic             scanning;
   logic             pick;
   logic [IDX_W-1:0] cur_idx;

   for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_entry
      logic fill_here;
      logic hit_here;
      logic dec_here;
      assign fill_here = fill_vld && (fill_idx == IDX_W'(gi));
      assign hit_here  = hit_vld  && (hit_idx  == IDX_W'(gi));
      assign dec_here  = scanning && !pick && (cur_idx == IDX_W'(gi));

      rvs_entry #(.CNT_W(CNT_W), .TPTR_W(TPTR_W)) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .fill_en  (fill_here),
         .fill_tptr(fill_tptr),
         .hit_en   (hit_here),
         .dec_en   (dec_here),
         .cnt_o    (cnt_a[gi]),
         .valid_o  (valid_a[gi]),
         .tptr_o   (tptr_a[gi])
      );
   end

   logic              cur_valid;
   logic              cur_zero;
   logic [TPTR_W-1:0] cur_tptr;

   assign cur_valid = valid_a[cur_idx];
   assign cur_zero  = (cnt_a[cur_idx] == '0);
   assign cur_tptr  = tptr_a[cur_idx];

   rvs_sweep #(.N_ENTRIES(N_ENTRIES), .TPTR_W(TPTR_W)) u_sweep (
      .clk            (clk),
      .rst_n          (rst_n),
      .req            (victim_req),
      .cur_valid      (cur_valid),
      .cur_zero       (cur_zero),
      .cur_tptr       (cur_tptr),
      .req_ready      (req_ready),
      .scanning       (scanning),
      .pick           (pick),
      .cur_idx        (cur_idx),
      .victim_valid   (victim_valid),
      .victim_idx     (victim_idx),
      .victim_tptr    (victim_tptr),
      .victim_occupied(victim_occupied)
   );
endmodule

// File: tb/sim_reuse_victim_sel.sv
module sim_reuse_victim_sel;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int CW = 2;
   localparam int TW = 6;
   localparam int IW = 3;
   localparam int CMAX = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hit_vld = 1'b0;
   logic [IW-1:0] hit_idx = '0;
   logic          fill_vld = 1'b0;
   logic [IW-1:0] fill_idx = '0;
   logic [TW-1:0] fill_tptr = '0;
   logic          victim_req = 1'b0;
   logic          req_ready;
   logic          victim_valid;
   logic [IW-1:0] victim_idx;
   logic [TW-1:0] victim_tptr;
   logic          victim_occupied;

   int checks = 0;
   int errors = 0;
   bit run_cmp = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   reuse_victim_sel #(.N_ENTRIES(N), .CNT_W(CW), .TPTR_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .hit_vld(hit_vld), .hit_idx(hit_idx),
      .fill_vld(fill_vld), .fill_idx(fill_idx), .fill_tptr(fill_tptr),
      .victim_req(victim_req), .req_ready(req_ready),
      .victim_valid(victim_valid), .victim_idx(victim_idx),
      .victim_tptr(victim_tptr), .victim_occupied(victim_occupied)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Requirement-level model, advanced on every rising edge.
   int m_cnt [N];
   int m_val [N];
   int m_tp  [N];
   int m_ptr, m_cur, m_busy, m_vv, m_vi, m_vt, m_vo;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_val[i] = 0; m_tp[i] = 0; end
         m_ptr = N - 1; m_cur = 0; m_busy = 0; m_vv = 0; m_vi = 0; m_vt = 0; m_vo = 0;
      end else begin
         int dec_on;
         int dec_ix;
         dec_on = 0; dec_ix = 0; m_vv = 0;
         if (m_busy != 0) begin
            if (m_val[m_cur] == 0 || m_cnt[m_cur] == 0) begin
               m_vv = 1; m_vi = m_cur; m_vt = m_tp[m_cur]; m_vo = m_val[m_cur];
               m_ptr = m_cur; m_busy = 0;
            end else begin
               dec_on = 1; dec_ix = m_cur; m_cur = (m_cur + 1) % N;
            end
         end else if (victim_req) begin
            m_busy = 1; m_cur = (m_ptr + 1) % N;
         end
         for (int i = 0; i < N; i++) begin
            bit f, h, d;
            f = fill_vld && (int'(fill_idx) == i);
            h = hit_vld  && (int'(hit_idx)  == i);
            d = (dec_on != 0) && (dec_ix == i);
            if (f) begin
               m_cnt[i] = 0; m_val[i] = 1; m_tp[i] = int'(fill_tptr);
            end else if (h && !d) begin
               if (m_cnt[i] < CMAX) m_cnt[i] = m_cnt[i] + 1;
            end else if (d && !h) begin
               if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (run_cmp && rst_n) begin
         chk(victim_valid == (m_vv != 0), "R7 victim_valid", int'(victim_valid), m_vv);
         chk(req_ready == (m_busy == 0), "R11 req_ready", int'(req_ready), int'(m_busy == 0));
         if (m_vv != 0 && victim_valid) begin
            chk(int'(victim_idx) == m_vi, "R5 victim_idx", int'(victim_idx), m_vi);
            chk(int'(victim_occupied) == m_vo, "R6 victim_occupied", int'(victim_occupied), m_vo);
            if (m_vo != 0)
               chk(int'(victim_tptr) == m_vt, "R2 victim_tptr", int'(victim_tptr), m_vt);
         end
      end
   end

   task automatic do_hit(input int idx);
      @(negedge clk); hit_vld = 1'b1; hit_idx = IW'(idx);
      @(negedge clk); hit_vld = 1'b0;
   endtask

   task automatic do_fill(input int idx, input int tp);
      @(negedge clk); fill_vld = 1'b1; fill_idx = IW'(idx); fill_tptr = TW'(tp);
      @(negedge clk); fill_vld = 1'b0;
   endtask

   task automatic get_victim(output int idx, output int occ, output int tp, output int lat);
      @(negedge clk); victim_req = 1'b1;
      @(negedge clk); victim_req = 1'b0;
      lat = 0;
      while (!victim_valid && lat < 200) begin @(negedge clk); lat++; end
      idx = int'(victim_idx); occ = int'(victim_occupied); tp = int'(victim_tptr);
   endtask

   initial begin
      int vi, vo, vt, lat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run_cmp = 1'b1;
      @(negedge clk);
      chk(victim_valid == 1'b0, "R1 reset victim_valid", int'(victim_valid), 0);
      chk(req_ready == 1'b1, "R1 reset req_ready", int'(req_ready), 1);

      // Empty array: victims come out in index order, one examined entry each.
      for (int i = 0; i < N; i++) begin
         get_victim(vi, vo, vt, lat);
         chk(vi == i, "R1 R6 empty sweep index", vi, i);
         chk(vo == 0, "R6 empty victim flag", vo, 0);
         chk(lat == 1, "R7 latency of empty pick", lat, 1);
         do_fill(i, i * 5 + 3);
      end

      // All valid with zero counts: pointer on 7, next search wraps to 0.
      get_victim(vi, vo, vt, lat);
      chk(vi == 0, "R5 wrap to index 0", vi, 0);
      chk(vo == 1, "R6 occupied victim flag", vo, 1);
      chk(vt == 3, "R2 stored back-pointer", vt, 3);
      do_fill(0, 9);

      // Counters: entry 1 -> 3, entry 2 hit five times -> saturates at 3, entry 3 -> 1.
      for (int k = 0; k < 3; k++) do_hit(1);
      for (int k = 0; k < 5; k++) do_hit(2);
      do_hit(3);
      get_victim(vi, vo, vt, lat);
      chk(vi == 4, "R3 R4 first zero after decrements", vi, 4);
      chk(lat == 4, "R7 four entries examined", lat, 4);
      chk(vt == 23, "R2 back-pointer of entry 4", vt, 23);
      do_fill(4, 40);

      // Wrap past the last index: 5,6,7 decremented to zero, entry 0 chosen.
      do_hit(5); do_hit(6); do_hit(7);
      get_victim(vi, vo, vt, lat);
      chk(vi == 0, "R5 wrap after decrementing 5..7", vi, 0);
      chk(lat == 4, "R7 wrap latency", lat, 4);

      // Pointer rests on 0: next search starts at 1; 1 and 2 drop to 1, 3 is zero.
      get_victim(vi, vo, vt, lat);
      chk(vi == 3, "R8 search resumes after last victim", vi, 3);
      chk(lat == 3, "R7 three entries examined", lat, 3);
      do_fill(3, 33);

      // Bring every count to 2, then hit entry 4 on the edge it is examined.
      do_hit(4); do_hit(4); do_hit(5); do_hit(5); do_hit(6); do_hit(6);
      do_hit(7); do_hit(7); do_hit(0); do_hit(0); do_hit(1); do_hit(2);
      do_hit(3); do_hit(3);
      @(negedge clk); victim_req = 1'b1;
      @(negedge clk); victim_req = 1'b0; hit_vld = 1'b1; hit_idx = IW'(4);
      @(negedge clk); hit_vld = 1'b0;
      lat = 1;
      while (!victim_valid && lat < 200) begin @(negedge clk); lat++; end
      vi = int'(victim_idx);
      chk(vi == 5, "R9 hit and decrement cancel", vi, 5);
      chk(lat == 18, "R9 three-lap latency", lat, 18);
      do_fill(5, 50);

      // Fill and hit on entry 6 in the same cycle: the fill wins, count zero.
      @(negedge clk);
      fill_vld = 1'b1; fill_idx = IW'(6); fill_tptr = TW'(61);
      hit_vld = 1'b1; hit_idx = IW'(6);
      @(negedge clk); fill_vld = 1'b0; hit_vld = 1'b0;
      get_victim(vi, vo, vt, lat);
      chk(vi == 6, "R10 fill wins over hit", vi, 6);
      chk(vt == 61, "R10 R2 back-pointer after fill", vt, 61);

      // Request while busy is ignored: pulse req during a running search.
      do_hit(7); do_hit(7);
      @(negedge clk); victim_req = 1'b1;
      @(negedge clk); victim_req = 1'b1;
      chk(req_ready == 1'b0, "R11 busy during search", int'(req_ready), 0);
      @(negedge clk); victim_req = 1'b0;
      repeat (40) @(negedge clk);

      // Pseudo-random mix of hits, fills and requests against the model.
      begin
         logic [31:0] r;
         r = 32'h1F2E_3D4C;
         for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            hit_vld    = r[0];
            hit_idx    = r[3:1];
            victim_req = r[4] & r[5];
            if (victim_valid) begin
               fill_vld = 1'b1; fill_idx = victim_idx;
            end else begin
               fill_vld = (r[9:6] == 4'd0); fill_idx = r[12:10];
            end
            fill_tptr = r[18:13];
         end
         @(negedge clk);
         hit_vld = 1'b0; victim_req = 1'b0; fill_vld = 1'b0;
      end
      repeat (60) @(negedge clk);
      run_cmp = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule